// File: doc/BRIEF.md
# Signature Compression Channel Controller

This block holds two 64-bit signature registers and a control register, all behind one simple register port. Each channel has a 2-bit mode. In capture mode, a write to a signature register loads the written word as it is, which is how a seed is planted. In any of the three compressing modes, the written word is folded into the signature with a 64-bit CRC step.

Channel 1 can also trace bus reads. When trace is on, read data from up to three monitored read ports is queued in a small holding queue. The queue takes the ports in a fixed priority order and drains one word per cycle into the channel 1 signature. A suspend input stops capture and drains while it is high.

Only privileged writes change the control register. Setting the trace bit forces channel 1 back to capture mode.

Top module: `psa_sig_ctrl`

## Requirements
- R1: The control register is at offset 0x10. Channel 1 mode is in bits 1:0, the trace enable in bit 4 and channel 2 mode in bits 9:8. All other bits read as 0, and writes to them have no effect.
- R2: A control write with `bus_priv_i` low leaves the modes and the trace enable unchanged.
- R3: A privileged control write with bit 4 set turns trace on and sets channel 1 mode to 0, whatever bits 1:0 carried.
- R4: The mode codes are 0 capture, 1 automatic, 2 semi-CPU and 3 full-CPU. In mode 0, a write to a signature register (channel 1 at 0x00, channel 2 at 0x08) loads the written word, which is visible on the next cycle.
- R5: In modes 1, 2 and 3, a write of word d changes signature s to ({s[62:0],0} XOR (s[63] ? 64'h42F0E1EBA9EA3693 : 0)) XOR d.
- R6: With trace on, valid words on the trace ports are queued at the clock edge they are presented. Queued words are compressed into channel 1 by the R5 step, one per cycle, port 0 first, then port 1, then port 2. The first of them starts on the following edge.
- R7: The holding queue has 4 entries. A word that finds the queue full (after that cycle's drain) is dropped, so a lower-numbered port is always accepted before a higher-numbered one.
- R8: While `suspend_i` is high, trace words are not queued, queued words are held, and the channel 1 signature does not change except by a CPU write.
- R9: A CPU write to channel 1 in the same cycle as a pending trace word takes effect first. The trace word is compressed on the next cycle.
- R10: Reset clears both signatures, both modes and the trace enable. Signatures read back at their offsets, and unmapped offsets read as 0.
- R11: With trace off, trace port activity has no effect, and the holding queue is kept empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_priv_i | input | 1 | Access is privileged |
| bus_addr_i | input | AW | Register byte offset |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data for `bus_addr_i` (combinational) |
| trc_vld_i | input | NPORT | Read-data valid per monitored port |
| trc_data_i | input | NPORT*64 | Read data, port n at bits n*64 upward |
| suspend_i | input | 1 | Freezes trace capture and compression |

## Verification
Four things are checked on every cycle: control readback with reserved bits at zero, user writes leaving the control state unchanged, the trace bit forcing capture mode, and seed loading. The same holds for the queue never exceeding its depth, the signature holding under suspend, and the queue staying empty with trace off. The CRC arithmetic, the priority order of same-cycle trace words, the dropped word on overflow and the ordering of a CPU write against a queued trace word need the bench's scenarios, since each depends on a sequence of values.

// File: rtl/psa_pkg.sv
package psa_pkg;
  parameter int unsigned SIG_W = 64;

  localparam int OFS_SIG1 = 'h00;
  localparam int OFS_SIG2 = 'h08;
  localparam int OFS_CTRL = 'h10;

  localparam int CH1_MODE_LSB = 0;
  localparam int TRC_BIT      = 4;
  localparam int CH2_MODE_LSB = 8;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_AUTO    = 2'd1,
    MODE_SEMI    = 2'd2,
    MODE_FULL    = 2'd3
  } psa_mode_e;

  function automatic logic [SIG_W-1:0] psa_step(input logic [SIG_W-1:0] sig,
                                                input logic [SIG_W-1:0] data,
                                                input logic [SIG_W-1:0] poly);
    return ({sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? poly : '0)) ^ data;
  endfunction
endpackage

// File: rtl/psa_ctrl_regs.sv
module psa_ctrl_regs
  import psa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       wr_ch1_mode_i,
  input  logic             wr_trc_i,
  input  logic [1:0]       wr_ch2_mode_i,
  output psa_mode_e        ch1_mode_o,
  output psa_mode_e        ch2_mode_o,
  output logic             trace_en_o,
  output logic [SIG_W-1:0] rdata_o
);
  psa_mode_e ch1_mode_q, ch2_mode_q;
  logic      trc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch1_mode_q <= MODE_CAPTURE;
      ch2_mode_q <= MODE_CAPTURE;
      trc_q      <= 1'b0;
    end else if (wr_i) begin
      ch2_mode_q <= psa_mode_e'(wr_ch2_mode_i);
      trc_q      <= wr_trc_i;
      // trace enable forces channel 1 into seed capture
      ch1_mode_q <= wr_trc_i ? MODE_CAPTURE : psa_mode_e'(wr_ch1_mode_i);
    end
  end

  always_comb begin
    rdata_o                          = '0;
    rdata_o[CH1_MODE_LSB +: 2]       = ch1_mode_q;
    rdata_o[TRC_BIT]                 = trc_q;
    rdata_o[CH2_MODE_LSB +: 2]       = ch2_mode_q;
  end

  assign ch1_mode_o = ch1_mode_q;
  assign ch2_mode_o = ch2_mode_q;
  assign trace_en_o = trc_q;
endmodule

// File: rtl/psa_sig_reg.sv
module psa_sig_reg
  import psa_pkg::*;
#(
  parameter logic [SIG_W-1:0] POLY = 64'h42F0E1EBA9EA3693
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_we_i,
  input  logic [SIG_W-1:0] cpu_data_i,
  input  psa_mode_e        mode_i,
  input  logic             trc_vld_i,
  input  logic [SIG_W-1:0] trc_data_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] sig_q, sig_d;

  always_comb begin
    sig_d = sig_q;
    if (cpu_we_i) begin
      sig_d = (mode_i == MODE_CAPTURE) ? cpu_data_i : psa_step(sig_q, cpu_data_i, POLY);
    end else if (trc_vld_i) begin
      sig_d = psa_step(sig_q, trc_data_i, POLY);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_d;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/psa_trace_queue.sv
module psa_trace_queue
  import psa_pkg::*;
#(
  parameter int unsigned NPORT = 3,
  parameter int unsigned DEPTH = 4,  // power of two, >= 2
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   push_en_i,
  input  logic [NPORT-1:0]       vld_i,
  input  logic [NPORT*SIG_W-1:0] data_i,
  input  logic                   pop_i,
  output logic                   vld_o,
  output logic [SIG_W-1:0]       data_o,
  output logic [CW-1:0]          count_o
);
  logic [SIG_W-1:0] mem_q [DEPTH];
  logic [SIG_W-1:0] mem_d [DEPTH];
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    mem_d = mem_q;
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop_i && cnt_q != '0) begin
      rd_d  = rd_q + PW'(1);
      cnt_d = cnt_q - CW'(1);
    end
    // lower port index takes the free slots first
    for (int i = 0; i < int'(NPORT); i++) begin
      if (push_en_i && vld_i[i] && cnt_d != CW'(DEPTH)) begin
        mem_d[wr_d] = data_i[i*SIG_W +: SIG_W];
        wr_d        = wr_d + PW'(1);
        cnt_d       = cnt_d + CW'(1);
      end
    end
    if (flush_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) mem_q <= mem_d;

  assign vld_o   = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/psa_sig_ctrl.sv
module psa_sig_ctrl
  import psa_pkg::*;
#(
  parameter int unsigned      AW    = 8,
  parameter int unsigned      NPORT = 3,
  parameter int unsigned      DEPTH = 4,
  parameter logic [SIG_W-1:0] POLY  = 64'h42F0E1EBA9EA3693
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_we_i,
  input  logic                   bus_priv_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic [SIG_W-1:0]       bus_wdata_i,
  output logic [SIG_W-1:0]       bus_rdata_o,
  input  logic [NPORT-1:0]       trc_vld_i,
  input  logic [NPORT*SIG_W-1:0] trc_data_i,
  input  logic                   suspend_i
);
  localparam int unsigned NCH = 2;
  localparam int unsigned CW  = $clog2(DEPTH + 1);

  logic             sel_sig1, sel_sig2, sel_ctrl;
  logic             ctrl_wr;
  logic [NCH-1:0]   sig_we;
  psa_mode_e        ch1_mode, ch2_mode;
  psa_mode_e        ch_mode [NCH];
  logic             trace_en;
  logic [SIG_W-1:0] ctrl_rdata;
  logic [SIG_W-1:0] sig_q [NCH];
  logic             q_vld, q_pop;
  logic [SIG_W-1:0] q_data;
  logic [CW-1:0]    q_cnt;

  assign sel_sig1  = (bus_addr_i == AW'(OFS_SIG1));
  assign sel_sig2  = (bus_addr_i == AW'(OFS_SIG2));
  assign sel_ctrl  = (bus_addr_i == AW'(OFS_CTRL));
  assign ctrl_wr   = bus_we_i && bus_priv_i && sel_ctrl;
  assign sig_we[0] = bus_we_i && sel_sig1;
  assign sig_we[1] = bus_we_i && sel_sig2;

  psa_ctrl_regs i_ctrl (
    .clk_i,
    .rst_ni,
    .wr_i          (ctrl_wr),
    .wr_ch1_mode_i (bus_wdata_i[CH1_MODE_LSB +: 2]),
    .wr_trc_i      (bus_wdata_i[TRC_BIT]),
    .wr_ch2_mode_i (bus_wdata_i[CH2_MODE_LSB +: 2]),
    .ch1_mode_o    (ch1_mode),
    .ch2_mode_o    (ch2_mode),
    .trace_en_o    (trace_en),
    .rdata_o       (ctrl_rdata)
  );

  // CPU write to channel 1 wins; queued trace word waits a cycle
  assign q_pop = q_vld && !suspend_i && !sig_we[0];

  psa_trace_queue #(.NPORT(NPORT), .DEPTH(DEPTH)) i_queue (
    .clk_i,
    .rst_ni,
    .flush_i   (!trace_en),
    .push_en_i (trace_en && !suspend_i),
    .vld_i     (trc_vld_i),
    .data_i    (trc_data_i),
    .pop_i     (q_pop),
    .vld_o     (q_vld),
    .data_o    (q_data),
    .count_o   (q_cnt)
  );

  assign ch_mode[0] = ch1_mode;
  assign ch_mode[1] = ch2_mode;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    psa_sig_reg #(.POLY(POLY)) i_sig (
      .clk_i,
      .rst_ni,
      .cpu_we_i   (sig_we[c]),
      .cpu_data_i (bus_wdata_i),
      .mode_i     (ch_mode[c]),
      .trc_vld_i  ((c == 0) ? q_pop : 1'b0),
      .trc_data_i ((c == 0) ? q_data : '0),
      .sig_o      (sig_q[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_sig1)      bus_rdata_o = sig_q[0];
    else if (sel_sig2) bus_rdata_o = sig_q[1];
    else if (sel_ctrl) bus_rdata_o = ctrl_rdata;
  end
endmodule

// File: rtl/psa_sig_ctrl_chk.sv
module psa_sig_ctrl_chk
  import psa_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic             bus_priv_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [SIG_W-1:0] bus_wdata_i,
  input logic [SIG_W-1:0] bus_rdata_o,
  input logic             suspend_i,
  input psa_mode_e        ch1_mode,
  input psa_mode_e        ch2_mode,
  input logic             trace_en,
  input logic [SIG_W-1:0] sig1,
  input logic [CW-1:0]    q_cnt
);
  localparam logic [SIG_W-1:0] RSVD = ~(SIG_W'(3) << CH1_MODE_LSB | SIG_W'(1) << TRC_BIT
                                        | SIG_W'(3) << CH2_MODE_LSB);

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == AW'(OFS_CTRL)) |-> ((bus_rdata_o & RSVD) == '0));

  assert_user_wr_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_priv_i) |=> ($stable(ch1_mode) && $stable(ch2_mode) && $stable(trace_en)));

  assert_trace_clears_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_priv_i && bus_addr_i == AW'(OFS_CTRL) && bus_wdata_i[TRC_BIT])
    |=> (trace_en && ch1_mode == MODE_CAPTURE));

  assert_seed_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(OFS_SIG1) && ch1_mode == MODE_CAPTURE)
    |=> (sig1 == $past(bus_wdata_i)));

  assert_queue_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= CW'(DEPTH));

  assert_suspend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !(bus_we_i && bus_addr_i == AW'(OFS_SIG1))) |=> $stable(sig1));

  assert_trace_off_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_en |=> (q_cnt == '0));
endmodule

bind psa_sig_ctrl psa_sig_ctrl_chk #(.AW(AW), .DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_priv_i  (bus_priv_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .suspend_i   (suspend_i),
  .ch1_mode    (ch1_mode),
  .ch2_mode    (ch2_mode),
  .trace_en    (trace_en),
  .sig1        (sig_q[0]),
  .q_cnt       (q_cnt)
);

// File: tb/test_psa_sig_ctrl.sv
module test_psa_sig_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;
  localparam logic [7:0]  A_SIG1 = 8'h00, A_SIG2 = 8'h08, A_CTRL = 8'h10, A_NONE = 8'h18;

  // {priv, wdata, expected control readback}
  localparam int NV = 7;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 64'h0000_0000_0000_0302, 16'h0302},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFEF, 16'h0303},
    {1'b0, 64'h0000_0000_0000_0000, 16'h0303},
    {1'b1, 64'h0000_0000_0000_0013, 16'h0010},
    {1'b0, 64'h0000_0000_0000_0201, 16'h0010},
    {1'b1, 64'h0000_0000_0000_0101, 16'h0101},
    {1'b1, 64'h0000_0000_0000_0000, 16'h0000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0, priv = 1'b0, suspend = 1'b0;
  logic [7:0]   addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic [2:0]   trc_vld = '0;
  logic [191:0] trc_data = '0;

  int n_chk = 0, n_bad = 0;
  logic [63:0] e1, e2;

  always #(CLK_PERIOD/2) clk = ~clk;

  psa_sig_ctrl i_psa_sig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_priv_i(priv), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .trc_vld_i(trc_vld), .trc_data_i(trc_data),
    .suspend_i(suspend)
  );

  function automatic logic [63:0] f_crc(input logic [63:0] s, input logic [63:0] d);
    return ({s[62:0], 1'b0} ^ (s[63] ? POLY : 64'h0)) ^ d;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic p);
    @(negedge clk); we = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk); we = 1'b0; priv = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
    addr = a; #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %h actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic trc_pulse(input logic [2:0] m, input logic [63:0] a, b, c);
    @(negedge clk); trc_vld = m; trc_data = {c, b, a};
    @(negedge clk); trc_vld = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_rd(A_SIG1, 64'h0, "R10 reset sig1");
    chk_rd(A_SIG2, 64'h0, "R10 reset sig2");
    chk_rd(A_CTRL, 64'h0, "R10 reset ctrl");
    rst_n = 1'b1;
    chk_rd(A_NONE, 64'h0, "R10 unmapped");

    // R1 R2 R3 control register table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, VEC[i][79:16], VEC[i][80]);
      chk_rd(A_CTRL, {48'h0, VEC[i][15:0]}, "R1/R2/R3 ctrl table");
    end

    // R4 R5 channel modes
    wr(A_CTRL, 64'h0, 1'b1);
    e2 = 64'h8123_4567_89AB_CDEF;
    wr(A_SIG2, e2, 1'b0);
    chk_rd(A_SIG2, e2, "R4 seed ch2");
    wr(A_CTRL, 64'h100, 1'b1);
    wr(A_SIG2, 64'h1111_2222_3333_4444, 1'b0);
    e2 = f_crc(e2, 64'h1111_2222_3333_4444);
    chk_rd(A_SIG2, e2, "R5 mode1 ch2");
    wr(A_CTRL, 64'h200, 1'b1);
    wr(A_SIG2, 64'hDEAD_BEEF_0000_0001, 1'b0);
    e2 = f_crc(e2, 64'hDEAD_BEEF_0000_0001);
    chk_rd(A_SIG2, e2, "R5 mode2 ch2");
    wr(A_CTRL, 64'h302, 1'b1);
    wr(A_SIG2, 64'hF0F0_0F0F_A5A5_5A5A, 1'b0);
    e2 = f_crc(e2, 64'hF0F0_0F0F_A5A5_5A5A);
    chk_rd(A_SIG2, e2, "R5 mode3 ch2");
    wr(A_SIG1, 64'h0123_0000_0000_0077, 1'b0);
    e1 = f_crc(64'h0, 64'h0123_0000_0000_0077);
    chk_rd(A_SIG1, e1, "R5 mode2 ch1");

    // R11 trace off ignores ports
    wr(A_CTRL, 64'h0, 1'b1);
    trc_pulse(3'b111, 64'h1, 64'h2, 64'h3);
    repeat (3) @(negedge clk);
    chk_rd(A_SIG1, e1, "R11 trace off");

    // R6 priority order, one per cycle
    wr(A_CTRL, 64'h10, 1'b1);
    e1 = 64'hC000_0000_0000_1234;
    wr(A_SIG1, e1, 1'b0);
    trc_pulse(3'b111, 64'hAAAA_0000_0000_0000, 64'h0000_BBBB_0000_0000, 64'h0000_0000_CCCC_0000);
    @(negedge clk); e1 = f_crc(e1, 64'hAAAA_0000_0000_0000);
    chk_rd(A_SIG1, e1, "R6 port0 first");
    @(negedge clk); e1 = f_crc(e1, 64'h0000_BBBB_0000_0000);
    chk_rd(A_SIG1, e1, "R6 port1 second");
    @(negedge clk); e1 = f_crc(e1, 64'h0000_0000_CCCC_0000);
    chk_rd(A_SIG1, e1, "R6 port2 third");

    // R7 overflow: second burst loses port 2
    @(negedge clk); trc_vld = 3'b111; trc_data = {64'hA2, 64'hA1, 64'h8000_0000_0000_00A0};
    @(negedge clk); trc_vld = 3'b111; trc_data = {64'hB2, 64'hB1, 64'hB0};
    @(negedge clk); trc_vld = '0;
    repeat (8) @(negedge clk);
    e1 = f_crc(e1, 64'h8000_0000_0000_00A0);
    e1 = f_crc(e1, 64'hA1); e1 = f_crc(e1, 64'hA2);
    e1 = f_crc(e1, 64'hB0); e1 = f_crc(e1, 64'hB1);
    chk_rd(A_SIG1, e1, "R7 overflow drop");

    // R8 suspend
    e1 = 64'h5555_AAAA_5555_AAAA;
    wr(A_SIG1, e1, 1'b0);
    suspend = 1'b1;
    trc_pulse(3'b111, 64'h7, 64'h8, 64'h9);
    repeat (4) @(negedge clk);
    chk_rd(A_SIG1, e1, "R8 no capture");
    suspend = 1'b0;
    @(negedge clk); trc_vld = 3'b011; trc_data = {64'h0, 64'h22, 64'h11};
    @(negedge clk); trc_vld = '0; suspend = 1'b1;
    repeat (4) @(negedge clk);
    chk_rd(A_SIG1, e1, "R8 queue held");
    suspend = 1'b0;
    repeat (4) @(negedge clk);
    e1 = f_crc(f_crc(e1, 64'h11), 64'h22);
    chk_rd(A_SIG1, e1, "R8 resume");

    // R9 CPU write beats queued trace word
    @(negedge clk); trc_vld = 3'b001; trc_data = {64'h0, 64'h0, 64'h3C3C};
    @(negedge clk); trc_vld = '0; we = 1'b1; addr = A_SIG1; wdata = 64'h9999_0000_1111_2222;
    @(negedge clk); we = 1'b0;
    chk_rd(A_SIG1, 64'h9999_0000_1111_2222, "R9 cpu first");
    @(negedge clk);
    chk_rd(A_SIG1, f_crc(64'h9999_0000_1111_2222, 64'h3C3C), "R9 trace after");

    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_rd(A_SIG1, 64'h0, "R10 mid reset sig1");
    chk_rd(A_CTRL, 64'h0, "R10 mid reset ctrl");
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule